// File: doc/BRIEF.md
# PWM Timebase with Delayed Sync Trigger

This block is the time reference for a pulse-width modulator. A prescale counter divides the system clock and produces a one-cycle tick. The tick comes once every `prescale + 1` clock cycles, or on every cycle when the prescale value is zero. On each tick a 16-bit main counter steps by one. On the tick where the main counter has reached the programmed period, it returns to zero instead of stepping, and a one-cycle wrap pulse marks the event.

A second compare produces a trigger for chaining several timebases. When the main counter equals the delay register on a prescale tick, a registered one-cycle `sync_o` pulse follows. A slave unit started from this pulse therefore runs a fixed number of ticks behind this one.

Software reaches the four registers through a plain synchronous port with one write strobe and a combinational read. The registers are the period, the prescale value, the sync delay and the live count. The upper bits of each read word return zero.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_i` is high at a clock edge, the following hold after that edge: the main counter and prescale counter are zero, and `sync_o` and `wrap_o` are low. After reset, addresses 0, 1 and 2 read 0x0000FFFF, and address 3 reads 0.
- R2: The main counter changes only on a prescale tick and then steps by one. With a prescale value of 0, a tick occurs on every clock cycle.
- R3: The prescale counter clears on the cycle where it has reached the prescale value Q, and that cycle is the tick. With period P, wrap pulses are therefore spaced exactly (P+1)*(Q+1) clock cycles apart.
- R4: `sync_o` is high for the cycle after a tick on which the main counter equals delay D. It follows a wrap pulse by (D+1)*(Q+1) cycles when D <= P, and it never asserts when D > P.
- R5: On a tick where the main counter is at or above the period, the counter goes to 0 and `wrap_o` is high for that one following cycle. In that cycle, address 3 reads 0.
- R6: Register map: address 0 is the period (ticks minus one), address 1 is the prescale value and address 2 is the sync delay. Each occupies bits 15:0. Write data bits 31:16 are dropped, and bits 31:16 read as zero.
- R7: Address 3 returns the live main counter. A write to address 3 leaves the counter unchanged.
- R8: A period write takes effect on the following edge. If the counter already exceeds the new period, it wraps to 0 on the next tick, and wrap pulses then follow the new spacing.
- R9: With a non-zero prescale value, each `sync_o` pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 period, 1 prescale, 2 delay, 3 count) |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, upper 16 bits zero |
| sync_o | output | 1 | One-cycle delayed trigger pulse |
| wrap_o | output | 1 | One-cycle period wrap pulse |

## Verification
Each programmed case is timed across a full period, so the bench catches the following faults:
- An off-by-one in the prescale reload would stretch or shorten the wrap spacing from (P+1)*(Q+1).
- A sync compare that ignored the tick would either repeat the pulse for Q+1 cycles or fire at the wrong offset.
- A delay set equal to the period must land on the wrap cycle, and a delay above the period must never fire.

The bench also shrinks the period below the running count. An equality-only wrap compare would then run the counter through its full 16-bit range instead of wrapping on the next tick.

Finally, the bench checks three things at the ports:
- Upper write bits are dropped.
- Writes to the count address are ignored.
- `sync_o` is forced low under reset even while its compare holds.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   localparam int PTB_ADDR_W = 2;

   typedef enum logic [PTB_ADDR_W-1:0] {
      REG_PERIOD   = 2'd0,
      REG_PRESCALE = 2'd1,
      REG_DELAY    = 2'd2,
      REG_COUNT    = 2'd3
   } ptb_addr_e;
endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
   import ptb_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  wr_en_i,
   input  logic [PTB_ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]      wr_data_i,
   input  logic [CNT_W-1:0]      cnt_i,
   output logic [CNT_W-1:0]      prd_o,
   output logic [CNT_W-1:0]      prsc_o,
   output logic [CNT_W-1:0]      dly_o,
   output logic [BUS_W-1:0]      rd_data_o
);
   localparam logic [CNT_W-1:0] RESET_VAL = '1;
   localparam int               PAD_W     = BUS_W - CNT_W;

   logic [CNT_W-1:0] prd_q, prsc_q, dly_q, sel;
   logic [BUS_W-1:0] rd_word;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prd_q  <= RESET_VAL;
         prsc_q <= RESET_VAL;
         dly_q  <= RESET_VAL;
      end else if (wr_en_i) begin
         case (ptb_addr_e'(addr_i))
            REG_PERIOD:   prd_q  <= wr_data_i[CNT_W-1:0];
            REG_PRESCALE: prsc_q <= wr_data_i[CNT_W-1:0];
            REG_DELAY:    dly_q  <= wr_data_i[CNT_W-1:0];
            default:      ;
         endcase
      end
   end

   always_comb begin
      case (ptb_addr_e'(addr_i))
         REG_PERIOD:   sel = prd_q;
         REG_PRESCALE: sel = prsc_q;
         REG_DELAY:    sel = dly_q;
         default:      sel = cnt_i;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign rd_word = {{PAD_W{1'b0}}, sel};
   end else begin : g_flat
      assign rd_word = sel;
   end

   if (RD_REG) begin : g_rd_q
      always_ff @(posedge clk_i) begin
         if (rst_i) rd_data_o <= '0;
         else       rd_data_o <= rd_word;
      end
   end else begin : g_rd_c
      assign rd_data_o = rd_word;
   end

   assign prd_o  = prd_q;
   assign prsc_o = prsc_q;
   assign dly_o  = dly_q;
endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] prsc_i,
   output logic [CNT_W-1:0] pre_o,
   output logic             tick_o
);
   logic [CNT_W-1:0] pre_q;

   // Magnitude compare so a freshly lowered limit ends the current interval at once.
   assign tick_o = (pre_q >= prsc_i);

   always_ff @(posedge clk_i) begin
      if (rst_i)       pre_q <= '0;
      else if (tick_o) pre_q <= '0;
      else             pre_q <= pre_q + 1'b1;
   end

   assign pre_o = pre_q;
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] prd_i,
   input  logic [CNT_W-1:0] dly_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o,
   output logic             sync_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             wrap_q, sync_q, at_end, at_dly;

   assign at_end = (cnt_q >= prd_i);
   assign at_dly = (cnt_q == dly_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         wrap_q <= tick_i & at_end;
         sync_q <= tick_i & at_dly;
         if (tick_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = wrap_q;
   assign sync_o = sync_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import ptb_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BUS_W  = 32,
   parameter bit RD_REG = 1'b0
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  wr_en_i,
   input  logic [PTB_ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]      wr_data_i,
   output logic [BUS_W-1:0]      rd_data_o,
   output logic                  sync_o,
   output logic                  wrap_o
);
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_width
      $error("pwm_timebase: CNT_W must lie in 2..BUS_W");
   end

   logic [CNT_W-1:0] prd_val, prsc_val, dly_val, cnt_val, pre_val;
   logic             tick;

   ptb_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .RD_REG(RD_REG)) u_regs (
      .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wr_data_i(wr_data_i), .cnt_i(cnt_val), .prd_o(prd_val),
      .prsc_o(prsc_val), .dly_o(dly_val), .rd_data_o(rd_data_o)
   );

   ptb_prescaler #(.CNT_W(CNT_W)) u_pre (
      .clk_i(clk_i), .rst_i(rst_i), .prsc_i(prsc_val),
      .pre_o(pre_val), .tick_o(tick)
   );

   ptb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .prd_i(prd_val),
      .dly_i(dly_val), .cnt_o(cnt_val), .wrap_o(wrap_o), .sync_o(sync_o)
   );
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] pre,
   input logic [CNT_W-1:0] prd,
   input logic [CNT_W-1:0] prsc,
   input logic [CNT_W-1:0] dly,
   input logic             sync_o,
   input logic             wrap_o
);
   p_reset_quiet_r1: assert property (@(posedge clk_i)
      rst_i |=> (!sync_o && !wrap_o && cnt == '0 && pre == '0));

   p_step_on_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick && cnt < prd) |=> (cnt == $past(cnt) + 1'b1));

   p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !tick |=> $stable(cnt));

   p_sync_source_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      sync_o |-> ($past(tick) && $past(cnt) == $past(dly)));

   p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap_o |-> (cnt == '0));

   p_sync_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (sync_o && prsc != '0) |=> !sync_o);
endmodule

bind pwm_timebase ptb_checker #(.CNT_W(CNT_W)) u_ptb_chk (
   .clk_i(clk_i), .rst_i(rst_i), .tick(tick), .cnt(cnt_val), .pre(pre_val),
   .prd(prd_val), .prsc(prsc_val), .dly(dly_val),
   .sync_o(sync_o), .wrap_o(wrap_o)
);

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd3;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        sync, wrap;
   int          n_tests = 0;
   int          n_fail  = 0;

   always #5 clk = ~clk;

   pwm_timebase i_pwm_timebase (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
      .wr_data_i(wdata), .rd_data_o(rdata), .sync_o(sync), .wrap_o(wrap)
   );

   // {period, prescale, delay}
   localparam int NV = 6;
   localparam logic [47:0] VEC [NV] = '{
      {16'd3, 16'd0, 16'd1},
      {16'd4, 16'd2, 16'd4},
      {16'd7, 16'd1, 16'd0},
      {16'd2, 16'd3, 16'd5},
      {16'd0, 16'd0, 16'd0},
      {16'd5, 16'd3, 16'd2}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd3;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
      addr = 2'd3;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      step(1);
   endtask

   initial begin
      logic [31:0] a, b, c;
      step(2);
      // R1: outputs low while held in reset
      check(!sync && !wrap, "R1", {30'd0, sync, wrap}, 32'd0);
      rst = 1'b0;
      step(1);
      for (int i = 0; i < 3; i++) begin
         reg_read(i[1:0], a);
         check(a == 32'h0000FFFF, "R1", a, 32'h0000FFFF);
      end
      reg_read(2'd3, a);
      check(a == 32'd0, "R1", a, 32'd0);

      // R6: upper write bits dropped, read as zero
      reg_write(2'd0, 32'hABCD_1234);
      reg_read(2'd0, a);
      check(a == 32'h0000_1234, "R6", a, 32'h0000_1234);
      reg_write(2'd2, 32'hFFFF_0007);
      reg_read(2'd2, a);
      check(a == 32'h0000_0007, "R6", a, 32'h0000_0007);

      // R2 / R7: count readback steps each cycle at prescale 0; count writes ignored
      do_reset();
      reg_write(2'd1, 32'd0);
      step(3);
      reg_read(2'd3, a);
      step(1);
      reg_read(2'd3, b);
      check(b == a + 1, "R2", b, a + 1);
      reg_write(2'd3, 32'd0);
      reg_read(2'd3, c);
      check(c == b + 1, "R7", c, b + 1);

      // R8: shrink period below running count
      do_reset();
      reg_write(2'd1, 32'd0);
      step(30);
      reg_read(2'd3, a);
      wr_en = 1'b1; addr = 2'd0; wdata = 32'd5;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd3;
      #1;
      check(!wrap && rdata == a + 1, "R8", rdata, a + 1);
      step(1);
      #1;
      check(wrap && rdata == 32'd0, "R8", {wrap, rdata[30:0]}, 32'h8000_0000);
      step(6);
      check(wrap == 1'b1, "R8", {31'd0, wrap}, 32'd1);

      // R1 / R4: sync held low under reset while compare keeps matching
      do_reset();
      reg_write(2'd1, 32'd0);
      reg_write(2'd0, 32'd0);
      reg_write(2'd2, 32'd0);
      step(2);
      check(sync == 1'b1, "R4", {31'd0, sync}, 32'd1);
      rst = 1'b1;
      step(1);
      #1;
      check(!sync && !wrap && rdata == 32'd0, "R1", {sync, wrap, rdata[29:0]}, 32'd0);
      rst = 1'b0;

      // Table walk: R3 spacing, R4 offset, R5 count at wrap, R9 width
      for (int v = 0; v < NV; v++) begin
         int unsigned prd_v, pre_v, dly_v, w_n, s_n, guard;
         bit wide, prev_s, cnt_bad;
         prd_v = VEC[v][47:32];
         pre_v = VEC[v][31:16];
         dly_v = VEC[v][15:0];
         do_reset();
         reg_write(2'd1, pre_v);
         reg_write(2'd0, prd_v);
         reg_write(2'd2, dly_v);
         guard = 0;
         while (!wrap && guard < 5000) begin
            step(1);
            guard++;
         end
         w_n = 0; s_n = 0; wide = 0; prev_s = 0; cnt_bad = 0;
         for (int n = 1; n < 5000; n++) begin
            step(1);
            #1;
            if (sync && s_n == 0) s_n = n;
            if (sync && prev_s && pre_v != 0) wide = 1;
            prev_s = sync;
            if (wrap) begin
               w_n = n;
               cnt_bad = (rdata != 32'd0);
               break;
            end
         end
         check(w_n == (prd_v + 1) * (pre_v + 1), "R3", w_n, (prd_v + 1) * (pre_v + 1));
         if (dly_v <= prd_v)
            check(s_n == (dly_v + 1) * (pre_v + 1), "R4", s_n, (dly_v + 1) * (pre_v + 1));
         else
            check(s_n == 0, "R4", s_n, 0);
         check(!cnt_bad, "R5", {31'd0, cnt_bad}, 32'd0);
         check(!wide, "R9", {31'd0, wide}, 32'd0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule